// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Peripheral Function Mux

This block is a memory-mapped general-purpose I/O port. Each of its pins is either driven by software through data and direction registers or handed over to one of several on-chip peripherals. Software programs it over a simple register bus. Data and direction each have write-one-to-set and write-one-to-clear aliases, so one pin can change without a read-modify-write. A separate input-enable mask decides which pad inputs reach the data read path.

Two registers make up the pin-ownership logic. A per-pin function-enable bit picks between GPIO mode and peripheral mode. A packed function-select register gives each pin a 2-bit field that picks which peripheral drives the pad output and the pad output-enable. The pad input passes through a reset-cleared synchronizer before it can be read. Pad electrical behaviour is handled outside this block.

Top module: `gpio_pinmux_port`

## Requirements
- R1: After reset all registers read as zero and every pad output-enable is low. Every pin is then a GPIO input with its input gated off.
- R2: A write to word 1 (data-set alias) sets the data latch bits where the written word has ones. All other data bits keep their value.
- R3: A write to word 2 (data-clear alias) clears the data latch bits where the written word has ones. All other data bits keep their value.
- R4: A write to word 4 (direction-set alias) makes the pins written with ones outputs. In the same cycle it clears their input-enable bits. Other pins are unchanged.
- R5: A write to word 5 (direction-clear alias) makes the pins written with ones inputs. Other pins are unchanged.
- R6: Whole-register writes and reads use word 0 for data, word 3 for direction, word 6 for input-enable, word 7 for function-enable and word 8 for function-select. Register bits above the register width read as zero. Words 9 to 15 read zero, and writes to them change no register.
- R7: A read of word 0 returns, for each pin, the data latch if its direction bit is 1. If the direction bit is 0 and input-enable is 1, it returns the pad input delayed by two clock edges. Otherwise it returns 0.
- R8: With function-enable bit n at 0, pad output n equals data bit n and pad output-enable n equals direction bit n.
- R9: With function-enable bit n at 1, pad output n and pad output-enable n come combinationally from peripheral f. Here f is function-select bits 2n+1:2n, and peripheral lines are indexed f*16+n.
- R10: A read of an alias word returns the current value of the underlying register. Words 1 and 2 return the raw data latch, and words 4 and 5 return the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| fn_out | input | 64 | Peripheral output values, line f*16+n for function f and pin n |
| fn_oe | input | 64 | Peripheral output-enables, same indexing |
| pad_in | input | 16 | Pad input values |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output-enables |

## Verification
The hardest state to reach is a port where each pin is in a different ownership mode at once: some GPIO outputs, some gated inputs, some open inputs, and peripheral pins that each select a different function. A single read then has to show every path. The bench builds this state with the set and clear aliases and a function-select value that gives every pin its own field. It drives a distinct pattern for each peripheral and checks every pad bit against a model computed in the bench. It also moves the pad input between reads to time the two-edge synchronizer latency, and it fills the input-enable mask before a direction-set to show the side effect on that mask.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
   localparam int REG_ADDR_W = 4;

   typedef enum logic [REG_ADDR_W-1:0] {
      RI_DATA    = 4'd0,
      RI_DSET    = 4'd1,
      RI_DCLR    = 4'd2,
      RI_DIR     = 4'd3,
      RI_DIRSET  = 4'd4,
      RI_DIRCLR  = 4'd5,
      RI_INEN    = 4'd6,
      RI_FEN     = 4'd7,
      RI_FSEL    = 4'd8
   } reg_idx_e;

   localparam logic [REG_ADDR_W-1:0] LAST_REG = 4'd8;
endpackage

// File: rtl/gpio_pinmux_sync.sv
module gpio_pinmux_sync #(
   parameter int NPINS  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] d,
   output logic [NPINS-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [NPINS-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpio_pinmux_regs.sv
module gpio_pinmux_regs
   import gpio_pinmux_pkg::*;
#(
   parameter int NPINS = 16,
   parameter int SEL_W = 2,
   parameter int BUS_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [REG_ADDR_W-1:0]  addr,
   input  logic [BUS_W-1:0]       wdata,
   output logic [BUS_W-1:0]       rdata,
   input  logic [NPINS-1:0]       pad_sync,
   output logic [NPINS-1:0]       data_q,
   output logic [NPINS-1:0]       dir_q,
   output logic [NPINS-1:0]       inen_q,
   output logic [NPINS-1:0]       fen_q,
   output logic [NPINS*SEL_W-1:0] fsel_q
);
   localparam int FS_W = NPINS * SEL_W;

   logic [NPINS-1:0] wbits;
   logic [NPINS-1:0] data_view;

   assign wbits = wdata[NPINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         inen_q <= '0;
         fen_q  <= '0;
         fsel_q <= '0;
      end else if (wr_en) begin
         case (addr)
            RI_DATA:   data_q <= wbits;
            RI_DSET:   data_q <= data_q | wbits;
            RI_DCLR:   data_q <= data_q & ~wbits;
            RI_DIR:    dir_q  <= wbits;
            RI_DIRSET: begin
               dir_q  <= dir_q | wbits;
               inen_q <= inen_q & ~wbits;
            end
            RI_DIRCLR: dir_q  <= dir_q & ~wbits;
            RI_INEN:   inen_q <= wbits;
            RI_FEN:    fen_q  <= wbits;
            RI_FSEL:   fsel_q <= wdata[FS_W-1:0];
            default:   ;
         endcase
      end
   end

   assign data_view = (dir_q & data_q) | (~dir_q & inen_q & pad_sync);

   always_comb begin
      rdata = '0;
      case (addr)
         RI_DATA:                     rdata[NPINS-1:0] = data_view;
         RI_DSET, RI_DCLR:            rdata[NPINS-1:0] = data_q;
         RI_DIR, RI_DIRSET, RI_DIRCLR: rdata[NPINS-1:0] = dir_q;
         RI_INEN:                     rdata[NPINS-1:0] = inen_q;
         RI_FEN:                      rdata[NPINS-1:0] = fen_q;
         RI_FSEL:                     rdata[FS_W-1:0]  = fsel_q;
         default:                     rdata = '0;
      endcase
   end

   // R2
   dset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RI_DSET) |=> data_q == ($past(data_q) | $past(wbits)));

   // R3
   dclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RI_DCLR) |=> data_q == ($past(data_q) & ~$past(wbits)));

   // R4
   dirset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RI_DIRSET) |=>
         (dir_q == ($past(dir_q) | $past(wbits))) && ((inen_q & $past(wbits)) == '0));

   // R5
   dirclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RI_DIRCLR) |=> dir_q == ($past(dir_q) & ~$past(wbits)));

   // R6
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr > LAST_REG) |=>
         $stable(data_q) && $stable(dir_q) && $stable(inen_q) && $stable(fen_q) && $stable(fsel_q));
endmodule

// File: rtl/gpio_pinmux_pin.sv
module gpio_pinmux_pin #(
   parameter int NFUNC = 4,
   parameter int SEL_W = 2
) (
   input  logic             fen,
   input  logic [SEL_W-1:0] fsel,
   input  logic             gpio_do,
   input  logic             gpio_oe,
   input  logic [NFUNC-1:0] per_do,
   input  logic [NFUNC-1:0] per_oe,
   output logic             pad_out,
   output logic             pad_oe
);
   always_comb begin
      pad_out = gpio_do;
      pad_oe  = gpio_oe;
      if (fen) begin
         pad_out = 1'b0;
         pad_oe  = 1'b0;
         for (int f = 0; f < NFUNC; f++) begin
            if (fsel == SEL_W'(f)) begin
               pad_out = per_do[f];
               pad_oe  = per_oe[f];
            end
         end
      end
   end
endmodule

// File: rtl/gpio_pinmux_port.sv
module gpio_pinmux_port
   import gpio_pinmux_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int NFUNC       = 4,
   parameter int BUS_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [REG_ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]       bus_wdata,
   output logic [BUS_W-1:0]       bus_rdata,
   input  logic [NFUNC*NPINS-1:0] fn_out,
   input  logic [NFUNC*NPINS-1:0] fn_oe,
   input  logic [NPINS-1:0]       pad_in,
   output logic [NPINS-1:0]       pad_out,
   output logic [NPINS-1:0]       pad_oe
);
   localparam int SEL_W = (NFUNC > 1) ? $clog2(NFUNC) : 1;
   localparam int FS_W  = NPINS * SEL_W;

   generate
      if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_pins
         $error("NPINS must lie between 1 and BUS_W");
      end
      if (FS_W > BUS_W) begin : g_bad_sel
         $error("function-select register exceeds bus width");
      end
      if (NFUNC < 1) begin : g_bad_func
         $error("NFUNC must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [NPINS-1:0] pad_sync;
   logic [NPINS-1:0] data_q, dir_q, inen_q, fen_q;
   logic [FS_W-1:0]  fsel_q;

   gpio_pinmux_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   gpio_pinmux_regs #(.NPINS(NPINS), .SEL_W(SEL_W), .BUS_W(BUS_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .pad_sync (pad_sync),
      .data_q   (data_q),
      .dir_q    (dir_q),
      .inen_q   (inen_q),
      .fen_q    (fen_q),
      .fsel_q   (fsel_q)
   );

   generate
      for (genvar n = 0; n < NPINS; n++) begin : g_pin
         logic [NFUNC-1:0] per_do, per_oe;
         for (genvar f = 0; f < NFUNC; f++) begin : g_fn
            assign per_do[f] = fn_out[f*NPINS + n];
            assign per_oe[f] = fn_oe[f*NPINS + n];
         end
         gpio_pinmux_pin #(.NFUNC(NFUNC), .SEL_W(SEL_W)) u_pin (
            .fen     (fen_q[n]),
            .fsel    (fsel_q[n*SEL_W +: SEL_W]),
            .gpio_do (data_q[n]),
            .gpio_oe (dir_q[n]),
            .per_do  (per_do),
            .per_oe  (per_oe),
            .pad_out (pad_out[n]),
            .pad_oe  (pad_oe[n])
         );
      end
   endgenerate

   // R8
   gpio_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fen_q == '0 && !bus_wr) |=> pad_oe == $past(dir_q));
endmodule

// File: tb/gpio_pinmux_port_tb.sv
`timescale 1ns/1ps
module gpio_pinmux_port_tb;
   localparam int N = 16;
   localparam int F = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [F*N-1:0] fn_out = '0;
   logic [F*N-1:0] fn_oe = '0;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_out, pad_oe;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [N-1:0]  m_data = '0, m_dir = '0, m_inen = '0, m_fen = '0;
   logic [31:0]   m_fsel = '0;

   always #5 clk = ~clk;

   gpio_pinmux_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fn_out(fn_out),
      .fn_oe(fn_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [15:0] nxt(input logic [15:0] x);
      return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
   endfunction

   function automatic logic [N-1:0] exp_pad(input bit oe);
      logic [N-1:0] r;
      for (int n = 0; n < N; n++) begin
         int f;
         f = int'(m_fsel[2*n +: 2]);
         if (m_fen[n]) r[n] = oe ? fn_oe[f*N+n] : fn_out[f*N+n];
         else          r[n] = oe ? m_dir[n] : m_data[n];
      end
      return r;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [15:0] p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 16; a++) begin
         rd(a[3:0], v);
         chk("R1 reset read", v, 32'h0);
      end
      chk("R1 reset pad_oe", {16'h0, pad_oe}, 32'h0);

      // R6 whole-register writes and readback
      p = 16'hACE1;
      for (int i = 0; i < 6; i++) begin
         wr(4'd3, {16'hFFFF, p});        m_dir = p;
         rd(4'd3, v); chk("R6 dir", v, {16'h0, p});
         wr(4'd6, {16'h0, ~p});          m_inen = ~p;
         rd(4'd6, v); chk("R6 inen", v, {16'h0, ~p});
         wr(4'd7, {16'h5555, p ^ 16'h0F0F}); m_fen = p ^ 16'h0F0F;
         rd(4'd7, v); chk("R6 fen", v, {16'h0, m_fen});
         wr(4'd8, {p, ~p});              m_fsel = {p, ~p};
         rd(4'd8, v); chk("R6 fsel", v, m_fsel);
         wr(4'd0, {16'h0, p ^ 16'h3C3C}); m_data = p ^ 16'h3C3C;
         wr(4'd3, 32'h0000FFFF);         m_dir = 16'hFFFF;
         rd(4'd0, v); chk("R6 data", v, {16'h0, m_data});
         p = nxt(p);
      end
      // R6 unmapped words
      for (int a = 9; a < 16; a++) begin
         wr(a[3:0], 32'hFFFFFFFF);
         rd(a[3:0], v); chk("R6 unmapped read", v, 32'h0);
      end
      rd(4'd3, v); chk("R6 unmapped no effect dir", v, {16'h0, m_dir});
      rd(4'd1, v); chk("R6 unmapped no effect data", v, {16'h0, m_data});
      rd(4'd8, v); chk("R6 unmapped no effect fsel", v, m_fsel);

      // R2 R3 single-bit sweep of set and clear aliases
      wr(4'd7, 32'h0); m_fen = '0;
      wr(4'd0, 32'h0); m_data = '0;
      for (int n = 0; n < N; n++) begin
         wr(4'd1, 32'h1 << n); m_data[n] = 1'b1;
         rd(4'd1, v); chk("R2 set bit", v, {16'h0, m_data});
      end
      for (int n = 0; n < N; n += 2) begin
         wr(4'd2, 32'h1 << n); m_data[n] = 1'b0;
         rd(4'd2, v); chk("R3 clear bit", v, {16'h0, m_data});
      end
      p = 16'h1D87;
      for (int i = 0; i < 8; i++) begin
         wr(4'd1, {16'hFFFF, p}); m_data = m_data | p;
         rd(4'd1, v); chk("R2 set pattern", v, {16'h0, m_data});
         p = nxt(p);
         wr(4'd2, {16'hFFFF, p}); m_data = m_data & ~p;
         rd(4'd2, v); chk("R3 clear pattern", v, {16'h0, m_data});
         p = nxt(p);
      end

      // R4 R5 direction aliases and input-enable side effect
      wr(4'd3, 32'h0); m_dir = '0;
      p = 16'h6B29;
      for (int i = 0; i < 8; i++) begin
         wr(4'd6, 32'h0000FFFF); m_inen = 16'hFFFF;
         wr(4'd4, {16'h0, p}); m_dir = m_dir | p; m_inen = m_inen & ~p;
         rd(4'd4, v); chk("R4 dir set", v, {16'h0, m_dir});
         rd(4'd6, v); chk("R4 inen cleared", v, {16'h0, m_inen});
         p = nxt(p);
         wr(4'd5, {16'h0, p}); m_dir = m_dir & ~p;
         rd(4'd5, v); chk("R5 dir clear", v, {16'h0, m_dir});
         rd(4'd6, v); chk("R5 inen untouched", v, {16'h0, m_inen});
         p = nxt(p);
      end

      // R10 alias reads return register values
      rd(4'd1, v); chk("R10 dset read", v, {16'h0, m_data});
      rd(4'd2, v); chk("R10 dclr read", v, {16'h0, m_data});
      rd(4'd4, v); chk("R10 dirset read", v, {16'h0, m_dir});
      rd(4'd5, v); chk("R10 dirclr read", v, {16'h0, m_dir});

      // R7 data read path with mixed directions and input gating
      wr(4'd3, 32'h0000F0F0); m_dir = 16'hF0F0;
      wr(4'd6, 32'h0000CCCC); m_inen = 16'hCCCC;
      wr(4'd0, 32'h0000AAAA); m_data = 16'hAAAA;
      p = 16'h2F51;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); pad_in = p;
         repeat (2) @(negedge clk);
         rd(4'd0, v);
         chk("R7 data view", v, {16'h0, (m_dir & m_data) | (~m_dir & m_inen & p)});
         p = nxt(p);
      end
      // R7 two-edge latency
      wr(4'd3, 32'h0); m_dir = '0;
      wr(4'd6, 32'h0000FFFF); m_inen = 16'hFFFF;
      @(negedge clk); pad_in = 16'h0000;
      repeat (3) @(negedge clk);
      pad_in = 16'hFFFF;
      @(negedge clk); #1 bus_addr = 4'd0;
      #1 chk("R7 after one edge", bus_rdata, 32'h0);
      @(negedge clk); #1
      chk("R7 after two edges", bus_rdata, 32'h0000FFFF);

      // R8 GPIO mode pad outputs
      wr(4'd7, 32'h0); m_fen = '0;
      p = 16'h9E37;
      for (int i = 0; i < 6; i++) begin
         wr(4'd0, {16'h0, p}); m_data = p;
         wr(4'd3, {16'h0, nxt(p)}); m_dir = nxt(p);
         @(negedge clk); #1
         chk("R8 pad_out", {16'h0, pad_out}, {16'h0, m_data});
         chk("R8 pad_oe", {16'h0, pad_oe}, {16'h0, m_dir});
         p = nxt(nxt(p));
      end

      // R9 function mode: each function on all pins
      for (int f = 0; f < F; f++) begin
         fn_out[f*N +: N] = 16'h3A5C ^ (16'h1111 * f[15:0]);
         fn_oe[f*N +: N]  = 16'hC3A5 + (16'h0707 * f[15:0]);
      end
      wr(4'd7, 32'h0000FFFF); m_fen = 16'hFFFF;
      for (int f = 0; f < F; f++) begin
         m_fsel = '0;
         for (int n = 0; n < N; n++) m_fsel[2*n +: 2] = f[1:0];
         wr(4'd8, m_fsel);
         @(negedge clk); #1
         chk("R9 pad_out uniform", {16'h0, pad_out}, {16'h0, exp_pad(0)});
         chk("R9 pad_oe uniform", {16'h0, pad_oe}, {16'h0, exp_pad(1)});
      end
      // R9 mixed ownership, per-pin function fields
      m_fsel = '0;
      for (int n = 0; n < N; n++) m_fsel[2*n +: 2] = 2'((n * 3 + 1) % 4);
      wr(4'd8, m_fsel);
      wr(4'd7, 32'h00005A3C); m_fen = 16'h5A3C;
      wr(4'd0, 32'h00009119); m_data = 16'h9119;
      wr(4'd3, 32'h0000E00F); m_dir = 16'hE00F;
      p = 16'h4321;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         fn_out = {fn_out[F*N-2:0], fn_out[F*N-1]} ^ {4{p}};
         fn_oe  = ~{fn_oe[0], fn_oe[F*N-1:1]};
         #1
         chk("R9 pad_out mixed", {16'h0, pad_out}, {16'h0, exp_pad(0)});
         chk("R9 pad_oe mixed", {16'h0, pad_oe}, {16'h0, exp_pad(1)});
         p = nxt(p);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule